// File: doc/BRIEF.md
# Complex Cross-Product Statistics Accumulator

Two complex sample streams, A and B, enter the block in lockstep and time-multiplexed: every valid cycle belongs to one statistic slot, and the slots repeat in a fixed block. For each valid cycle the block multiplies A by the complex conjugate of B and adds the product to that slot's running real and imaginary totals. The totals live in a per-slot accumulation memory with a two-cycle read latency.

A single-cycle sync pulse closes an integration interval. The pulse is presented on the same port cycle as the first sample of the new interval. The block delays data and valid by one internal register stage, so the slot counter restarts exactly when that first sample reaches the accumulator. During the first pass over the slots after a sync, each slot's stored total is emitted on a write stream tagged with the slot address, and the slot is reloaded with the new product instead of being added to. The emitted values are therefore the complete sums of the interval that just ended, and the integration time equals the number of blocks between syncs. A downstream statistics register consumes this write stream.

Top module: `xps_stat_acc`

## Requirements
- R1: The real total of a slot is the sum, over the interval's valid samples mapped to that slot, of a_re*b_re + a_im*b_im, held in a signed ACC_W-bit accumulator without loss for full-scale IN_W-bit inputs.
- R2: The imaginary total of a slot is the sum of a_im*b_re - a_re*b_im over the same samples.
- R3: There are N_CROSS*N_INPUTS*N_INPUTS slots. Slot k = (c*N_INPUTS + i)*N_INPUTS + j pairs A element c*N_INPUTS+i with B element c*N_INPUTS+j. The slot index advances by one per valid sample, wraps from the last slot to 0, and is forced to 0 by sync. Dump addresses follow the same order.
- R4: Cycles with in_valid low neither advance the slot index nor change any total, whatever the data inputs carry.
- R5: A sync starts a new interval. During the first pass after it, slot k's dump carries the totals of the interval just ended, and the new interval's totals start from the first new product alone.
- R6: The dump for a slot appears with dump_wr high exactly 4 clock cycles after the port cycle of the first-pass sample for that slot, one slot per dump cycle.
- R7: Synchronous active-high reset clears dump_wr and the slot index. No dump is produced before the first sync after reset.
- R8: A slot never written since reset reads as zero. A sync that follows a partial pass therefore dumps zero for the slots that were not reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sync | input | 1 | Single-cycle interval start, presented with the first sample of the interval |
| in_valid | input | 1 | Sample valid for A and B |
| a_re | input | IN_W | Stream A real part, signed |
| a_im | input | IN_W | Stream A imaginary part, signed |
| b_re | input | IN_W | Stream B real part, signed |
| b_im | input | IN_W | Stream B imaginary part, signed |
| dump_wr | output | 1 | Dump write strobe |
| dump_slot | output | AW | Slot address of the dumped totals |
| dump_re | output | ACC_W | Dumped real total, signed |
| dump_im | output | ACC_W | Dumped imaginary total, signed |

## Verification
The assertions assume that in_sync only arrives together with a valid sample, and only on a block boundary. This keeps a slot from being read again before its previous write has landed in the two-cycle memory. The address-order property also assumes that every interval covers at least one full block. The stimulus opens every interval with a sync on slot 0 and drives whole blocks, including blocks with idle gaps between samples. The one partial pass comes before the first sync and is followed by a long idle stretch, so its last write has completed before the sync.

// File: rtl/xps_pkg.sv
package xps_pkg;
  // Address width with a floor of one bit.
  function automatic int addr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
  typedef enum logic [0:0] {PART_RE = 1'b0, PART_IM = 1'b1} part_e;
  localparam int NUM_PARTS = 2;
  localparam int MIN_SLOTS = 8;
endpackage

// File: rtl/xps_slot_seq.sv
module xps_slot_seq #(
  parameter int N_SLOTS = 8,
  parameter int AW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_i,
  input  logic          adv_i,
  output logic [AW-1:0] slot_o,
  output logic          first_o,
  output logic          dump_o
);
  localparam logic [AW-1:0] LAST = AW'(N_SLOTS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_o  <= '0;
      first_o <= 1'b1;
      dump_o  <= 1'b0;
    end else if (sync_i) begin
      slot_o  <= '0;
      first_o <= 1'b1;
      dump_o  <= 1'b1;
    end else if (adv_i) begin
      if (slot_o == LAST) begin
        slot_o  <= '0;
        first_o <= 1'b0;
      end else begin
        slot_o <= slot_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xps_conj_mult.sv
module xps_conj_mult #(
  parameter int IN_W   = 18,
  parameter int PROD_W = 2 * IN_W + 1
) (
  input  logic                     clk,
  input  logic signed [IN_W-1:0]   a_re,
  input  logic signed [IN_W-1:0]   a_im,
  input  logic signed [IN_W-1:0]   b_re,
  input  logic signed [IN_W-1:0]   b_im,
  output logic signed [PROD_W-1:0] prod_re,
  output logic signed [PROD_W-1:0] prod_im
);
  localparam int MW = 2 * IN_W;

  logic signed [MW-1:0] m_rr, m_ii, m_ir, m_ri;

  assign m_rr = a_re * b_re;
  assign m_ii = a_im * b_im;
  assign m_ir = a_im * b_re;
  assign m_ri = a_re * b_im;

  // A times conj(B), registered once
  always_ff @(posedge clk) begin
    prod_re <= {m_rr[MW-1], m_rr} + {m_ii[MW-1], m_ii};
    prod_im <= {m_ir[MW-1], m_ir} - {m_ri[MW-1], m_ri};
  end
endmodule

// File: rtl/xps_sum_ram.sv
module xps_sum_ram #(
  parameter int DW    = 54,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q1;

  // Registered read plus output register: two cycles of read latency
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) q1 <= mem[rd_addr];
    rd_data <= q1;
  end
endmodule

// File: rtl/xps_stat_acc.sv
module xps_stat_acc #(
  parameter  int IN_W     = 18,
  parameter  int ACC_W    = 54,
  parameter  int N_CROSS  = 2,
  parameter  int N_INPUTS = 2,
  localparam int N_SLOTS  = N_CROSS * N_INPUTS * N_INPUTS,
  localparam int AW       = xps_pkg::addr_bits(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_sync,
  input  logic               in_valid,
  input  logic [IN_W-1:0]    a_re,
  input  logic [IN_W-1:0]    a_im,
  input  logic [IN_W-1:0]    b_re,
  input  logic [IN_W-1:0]    b_im,
  output logic               dump_wr,
  output logic [AW-1:0]      dump_slot,
  output logic [ACC_W-1:0]   dump_re,
  output logic [ACC_W-1:0]   dump_im
);
  import xps_pkg::*;

  localparam int PROD_W = 2 * IN_W + 1;
  localparam int EXT_W  = ACC_W - PROD_W;

  if (N_SLOTS < MIN_SLOTS) begin : g_bad_slots
    $error("xps_stat_acc: slot count below the read-after-write limit");
  end
  if (EXT_W < 1) begin : g_bad_acc
    $error("xps_stat_acc: accumulator narrower than one product");
  end

  // Input stage: data and valid one cycle behind the sync
  logic                   d_v;
  logic signed [IN_W-1:0] d_are, d_aim, d_bre, d_bim;

  always_ff @(posedge clk) begin
    if (rst) d_v <= 1'b0;
    else     d_v <= in_valid;
    d_are <= a_re;
    d_aim <= a_im;
    d_bre <= b_re;
    d_bim <= b_im;
  end

  // Stage 0: slot sequencing and memory read
  logic [AW-1:0] s0_slot;
  logic          s0_first, s0_dump;
  logic [N_SLOTS-1:0] filled;

  xps_slot_seq #(.N_SLOTS(N_SLOTS), .AW(AW)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .sync_i (in_sync),
    .adv_i  (d_v),
    .slot_o (s0_slot),
    .first_o(s0_first),
    .dump_o (s0_dump)
  );

  logic signed [PROD_W-1:0] p1_re, p1_im;

  xps_conj_mult #(.IN_W(IN_W), .PROD_W(PROD_W)) u_mul (
    .clk    (clk),
    .a_re   (d_are),
    .a_im   (d_aim),
    .b_re   (d_bre),
    .b_im   (d_bim),
    .prod_re(p1_re),
    .prod_im(p1_im)
  );

  // Stage 1 and stage 2 control and product pipeline
  logic          s1_v, s1_first, s1_dump, s1_seen;
  logic [AW-1:0] s1_slot;
  logic          s2_v, s2_first, s2_dump, s2_seen;
  logic [AW-1:0] s2_slot;
  logic signed [PROD_W-1:0] s2_pre, s2_pim;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      s1_v <= d_v;
      s2_v <= s1_v;
    end
    s1_slot  <= s0_slot;
    s1_first <= s0_first;
    s1_dump  <= s0_dump;
    s1_seen  <= filled[s0_slot];
    s2_slot  <= s1_slot;
    s2_first <= s1_first;
    s2_dump  <= s1_dump;
    s2_seen  <= s1_seen;
    s2_pre   <= p1_re;
    s2_pim   <= p1_im;
  end

  // Marks slots written since reset
  always_ff @(posedge clk) begin
    if (rst)       filled <= '0;
    else if (s2_v) filled[s2_slot] <= 1'b1;
  end

  // Stage 2: read-modify-write per part
  logic signed [ACC_W-1:0] prod_x [NUM_PARTS];
  logic signed [ACC_W-1:0] old_x  [NUM_PARTS];
  logic signed [ACC_W-1:0] new_x  [NUM_PARTS];
  logic        [ACC_W-1:0] rdq    [NUM_PARTS];

  assign prod_x[PART_RE] = {{EXT_W{s2_pre[PROD_W-1]}}, s2_pre};
  assign prod_x[PART_IM] = {{EXT_W{s2_pim[PROD_W-1]}}, s2_pim};

  for (genvar gp = 0; gp < NUM_PARTS; gp++) begin : g_part
    xps_sum_ram #(.DW(ACC_W), .DEPTH(N_SLOTS), .AW(AW)) u_ram (
      .clk    (clk),
      .rd_en  (d_v),
      .rd_addr(s0_slot),
      .wr_en  (s2_v),
      .wr_addr(s2_slot),
      .wr_data(new_x[gp]),
      .rd_data(rdq[gp])
    );
    assign old_x[gp] = s2_seen  ? $signed(rdq[gp]) : '0;
    assign new_x[gp] = s2_first ? prod_x[gp] : old_x[gp] + prod_x[gp];
  end

  // Registered dump stream
  always_ff @(posedge clk) begin
    if (rst) dump_wr <= 1'b0;
    else     dump_wr <= s2_v && s2_first && s2_dump;
    dump_slot <= s2_slot;
    dump_re   <= old_x[PART_RE];
    dump_im   <= old_x[PART_IM];
  end
endmodule

// File: rtl/xps_stat_acc_chk.sv
module xps_stat_acc_chk #(
  parameter int N_SLOTS = 8,
  parameter int AW      = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          in_sync,
  input logic          in_valid,
  input logic          dump_wr,
  input logic [AW-1:0] dump_slot
);
  logic          synced;
  logic [3:0]    sync_d;
  logic [AW-1:0] exp_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      synced   <= 1'b0;
      sync_d   <= '0;
      exp_slot <= '0;
    end else begin
      if (in_sync) synced <= 1'b1;
      sync_d <= {sync_d[2:0], in_sync};
      if (dump_wr)
        exp_slot <= (dump_slot == AW'(N_SLOTS - 1)) ? '0 : dump_slot + 1'b1;
    end
  end

  // R7: reset silences the dump stream
  p_reset_quiet_r7: assert property (@(posedge clk) rst |=> !dump_wr);

  // R7: nothing is dumped before the first sync
  p_no_dump_unsynced_r7: assert property (@(posedge clk) disable iff (rst)
    !synced |-> !dump_wr);

  // R5 / R6: a sync with its first sample dumps slot 0 four cycles later
  p_sync_dump_slot0_r5: assert property (@(posedge clk) disable iff (rst)
    (in_sync && in_valid) |=> ##3 (dump_wr && dump_slot == '0));

  // R4: an idle port cycle yields no dump four cycles later
  p_idle_no_dump_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##3 !dump_wr);

  // R3: dump addresses step in slot order and restart at 0 after sync
  p_slot_order_r3: assert property (@(posedge clk) disable iff (rst)
    dump_wr |-> dump_slot == (sync_d[3] ? '0 : exp_slot));
endmodule

bind xps_stat_acc xps_stat_acc_chk #(.N_SLOTS(N_SLOTS), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_sync  (in_sync),
  .in_valid (in_valid),
  .dump_wr  (dump_wr),
  .dump_slot(dump_slot)
);

// File: tb/xps_stat_acc_bench.sv
module xps_stat_acc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W  = 18;
  localparam int ACC_W = 54;
  localparam int NC    = 2;
  localparam int NI    = 2;
  localparam int NS    = NC * NI * NI;
  localparam int NE    = NC * NI;
  localparam int AW    = 3;
  localparam int LAT   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_sync = 1'b0, in_valid = 1'b0;
  logic [IN_W-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic dump_wr;
  logic [AW-1:0] dump_slot;
  logic [ACC_W-1:0] dump_re, dump_im;

  always #(CLK_PERIOD/2) clk = ~clk;

  xps_stat_acc #(.IN_W(IN_W), .ACC_W(ACC_W), .N_CROSS(NC), .N_INPUTS(NI)) u_xps_stat_acc (
    .clk(clk), .rst(rst), .in_sync(in_sync), .in_valid(in_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .dump_wr(dump_wr), .dump_slot(dump_slot), .dump_re(dump_re), .dump_im(dump_im)
  );

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_bad = 0;
  int n_dumps = 0;

  typedef struct {
    longint cyc;
    int     slot;
    longint re;
    longint im;
    int     scn;
  } item_t;
  item_t sbq[$];

  longint cur_are[NE], cur_aim[NE], cur_bre[NE], cur_bim[NE];
  longint mdl_re[NS], mdl_im[NS], prv_re[NS], prv_im[NS];
  bit synced = 1'b0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input int req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint rnd8();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return longint'($signed(lf[7:0]));
  endfunction

  task automatic load_random();
    for (int e = 0; e < NE; e++) begin
      cur_are[e] = rnd8(); cur_aim[e] = rnd8();
      cur_bre[e] = rnd8(); cur_bim[e] = rnd8();
    end
  endtask

  // Full-scale operands for the R1 width case
  task automatic load_extreme();
    for (int e = 0; e < NE; e++) begin
      cur_are[e] = -131072; cur_aim[e] = -131072;
      cur_bre[e] = -131072; cur_bim[e] = 131071;
    end
  endtask

  // Driver: one sample at a negedge; expected dump items go into the queue
  task automatic drive_sample(input int k, input bit sy, input bit push, input int scn);
    int c, i, j, ea, eb;
    c = k / (NI * NI);
    i = (k / NI) % NI;
    j = k % NI;
    ea = c * NI + i;
    eb = c * NI + j;
    if (sy) begin
      for (int s = 0; s < NS; s++) begin
        prv_re[s] = mdl_re[s]; prv_im[s] = mdl_im[s];
        mdl_re[s] = 0;         mdl_im[s] = 0;
      end
      synced = 1'b1;
    end
    in_sync  = sy;
    in_valid = 1'b1;
    a_re = cur_are[ea][IN_W-1:0];
    a_im = cur_aim[ea][IN_W-1:0];
    b_re = cur_bre[eb][IN_W-1:0];
    b_im = cur_bim[eb][IN_W-1:0];
    mdl_re[k] += cur_are[ea] * cur_bre[eb] + cur_aim[ea] * cur_bim[eb];
    mdl_im[k] += cur_aim[ea] * cur_bre[eb] - cur_are[ea] * cur_bim[eb];
    if (push && synced)
      sbq.push_back('{cyc: cyc + LAT, slot: k, re: prv_re[k], im: prv_im[k], scn: scn});
    @(negedge clk);
  endtask

  // Idle cycles carry junk data with valid low (R4)
  task automatic idle(input int n);
    in_sync = 1'b0;
    in_valid = 1'b0;
    a_re = IN_W'(rnd8() * 1000); a_im = IN_W'(rnd8() * 999);
    b_re = IN_W'(rnd8() * 777);  b_im = IN_W'(rnd8() * 555);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_interval(input int nblk, input int gapblk, input int scn);
    for (int b = 0; b < nblk; b++) begin
      for (int k = 0; k < NS; k++) begin
        drive_sample(k, (b == 0) && (k == 0), b == 0, scn);
        if (b == gapblk && (k % 2) == 1) idle(2);
      end
    end
  endtask

  // Monitor: pops and compares each dump as it appears
  always @(negedge clk) begin
    if (!rst && dump_wr) begin
      n_dumps++;
      if (sbq.size() == 0) begin
        chk(1'b0, 7, "unexpected dump, slot", longint'(dump_slot), -1);
      end else begin
        item_t it;
        it = sbq.pop_front();
        chk(cyc == it.cyc, 6, $sformatf("dump cycle (scn R%0d)", it.scn), cyc, it.cyc);
        chk(int'(dump_slot) == it.slot, 3, $sformatf("dump slot (scn R%0d)", it.scn),
            longint'(dump_slot), it.slot);
        chk(longint'($signed(dump_re)) == it.re, 1,
            $sformatf("real total slot %0d (scn R%0d)", it.slot, it.scn),
            longint'($signed(dump_re)), it.re);
        chk(longint'($signed(dump_im)) == it.im, 2,
            $sformatf("imag total slot %0d (scn R%0d)", it.slot, it.scn),
            longint'($signed(dump_im)), it.im);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_bad++;
    $display("FAIL R6 watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      mdl_re[s] = 0; mdl_im[s] = 0; prv_re[s] = 0; prv_im[s] = 0;
    end
    repeat (5) @(negedge clk);
    chk(dump_wr == 1'b0, 7, "dump_wr in reset", longint'(dump_wr), 0);
    rst = 1'b0;
    idle(3);

    // R7 and R8: partial pass with no sync, only slots 0..2 written
    load_random();
    drive_sample(0, 1'b0, 1'b0, 8);
    drive_sample(1, 1'b0, 1'b0, 8);
    drive_sample(2, 1'b0, 1'b0, 8);
    idle(12);
    chk(n_dumps == 0, 7, "dumps before first sync", n_dumps, 0);

    // First sync: dumps the partial pass, unreached slots zero (R8)
    load_random();
    run_interval(2, -1, 8);
    // Two-block interval dumped at next sync (R5); this one has gaps (R4)
    load_random();
    run_interval(3, 1, 5);
    // Gapped interval dumped here (R4); full-scale operands start (R1)
    load_extreme();
    run_interval(3, 0, 4);
    // Full-scale totals dumped here (R1, R2)
    load_random();
    run_interval(1, -1, 1);
    // Single-block interval dumped here (R5)
    load_random();
    run_interval(1, -1, 5);
    idle(12);

    chk(sbq.size() == 0, 6, "expected dumps left over", sbq.size(), 0);
    chk(n_dumps == 5 * NS, 3, "dump count", n_dumps, 5 * NS);
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule